// File: doc/BRIEF.md
# Card Data FIFO with Threshold-Driven DMA Requests

This block is the data buffer between the register interface of a memory-card host and its card-side shifter. It holds up to 32 sixteen-bit words. The direction of the current transfer decides which side may write and which side may read. In the receive direction the card side fills the buffer and software or DMA empties it through the register port. In the transmit direction the register port fills it and the card side drains it.

Two programmable thresholds watch the occupancy: an upper level for receive and a lower level for transmit. When a threshold is crossed, the block raises a DMA request if DMA is enabled for that direction. If DMA is disabled, it raises a status flag instead, so an interrupt handler can move the data by hand.

A small three-state controller decides which threshold is in force:
- `LV_QUIET`: no transfer is running and the buffer is empty.
- `LV_RECV`: receive direction.
- `LV_SEND`: transmit direction.

On every clock the controller moves to `LV_QUIET` when the transfer-active input is low and the next occupancy is zero. Otherwise it moves to `LV_RECV` when the direction input is 1, or to `LV_SEND` when it is 0.

Top module: `card_fifo_dma`

## Requirements
- R1: The buffer stores words in first-in first-out order. `fifo_rdata` always shows the oldest stored word. `level` reports occupancy from 0 to 32. A push and a pop in the same cycle leave `level` unchanged.
- R2: With `xfer_dir`=1 (receive), `card_push` writes and `reg_pop` reads. With `xfer_dir`=0 (transmit), `reg_push` writes and `card_pop` reads. Strobes from the side not selected by the direction have no effect on `level` or on the stored data.
- R3: A push while `level` is 32 is dropped. `level` stays 32 and the stored data is not altered, even when a pop happens in the same cycle.
- R4: A pop while the buffer is empty leaves `level` and `fifo_rdata` unchanged. `underrun` is high for exactly the one cycle that follows that clock edge.
- R5: In `LV_RECV`, if `level` is greater than the upper level: `rx_dma_req` is high when receive DMA is enabled, and `rx_flag` is high when it is disabled. Otherwise both are low. The transmit outputs are low in this state.
- R6: In `LV_SEND`, if `level` is less than the lower level: `tx_dma_req` is high when transmit DMA is enabled, and `tx_flag` is high when it is disabled. Otherwise both are low. The receive outputs are low in this state.
- R7: In `LV_QUIET` (transfer inactive and buffer empty), all four request and flag outputs are low. When the transfer is inactive but the buffer still holds data, the state set by `xfer_dir` continues to apply.
- R8: The configuration word layout is as follows:
  - bit 15: receive DMA enable
  - bits 12:8: upper level
  - bit 7: transmit DMA enable
  - bits 4:0: lower level

  `cfg_rdata` returns this word, with all other bits reading 0. After reset it reads 16'h1F00 (upper level 31, lower level 0, both DMA enables off).
- R9: The requests and flags follow the registers written at the preceding clock edge. Turning a direction's DMA enable on drops that direction's flag in the same cycle the request rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_dir | input | 1 | 1 = receive (card to host), 0 = transmit |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Current configuration word |
| reg_push | input | 1 | Register-side write of a data word |
| reg_pop | input | 1 | Register-side read of a data word |
| reg_wdata | input | 16 | Data word from the register side |
| card_push | input | 1 | Card-side write of a data word |
| card_pop | input | 1 | Card-side read of a data word |
| card_wdata | input | 16 | Data word from the card side |
| fifo_rdata | output | 16 | Oldest stored word, shared by both readers |
| level | output | 6 | Current occupancy |
| underrun | output | 1 | One-cycle pulse after a pop from an empty buffer |
| rx_dma_req | output | 1 | Receive DMA request |
| rx_flag | output | 1 | Receive threshold status when DMA is off |
| tx_dma_req | output | 1 | Transmit DMA request |
| tx_flag | output | 1 | Transmit threshold status when DMA is off |

## Verification
On every cycle, the assertions check the following:
- occupancy stays within bounds;
- a push at full and a pop at empty leave the occupancy as stated;
- the underrun pulse appears only after a pop on an empty buffer;
- a request and its flag are never high together, and each agrees with the enable bit read back;
- the receive and transmit sides are never active at once;
- all outputs are quiet once an idle transfer has drained the buffer.

Only the bench scenarios can show the rest: that words leave in the order they entered, that the dropped push at full did not corrupt stored data, and that the strict greater-than and less-than comparisons fire at exactly the right occupancy, including the reset upper level of 31 at a full buffer.

// File: rtl/cfd_pkg.sv
package cfd_pkg;

    // Threshold controller states
    typedef enum logic [1:0] {
        LV_QUIET = 2'd0,
        LV_RECV  = 2'd1,
        LV_SEND  = 2'd2
    } lvl_state_e;

    // Configuration word bit positions (behavioural: software encodes these)
    localparam int unsigned CFG_W        = 16;
    localparam int unsigned CFG_RX_EN    = 15;
    localparam int unsigned CFG_HI_LSB   = 8;
    localparam int unsigned CFG_TX_EN    = 7;
    localparam int unsigned CFG_LO_LSB   = 0;

endpackage

// File: rtl/cfd_store.sv
// Circular word store: read pointer plus occupancy count. DEPTH must be a power of two.
module cfd_store #(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 32,
    parameter int unsigned PTR_W  = $clog2(DEPTH),
    parameter int unsigned CNT_W  = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pop,
    output logic [DATA_W-1:0] rdata,
    output logic [CNT_W-1:0]  count,
    output logic [CNT_W-1:0]  count_nxt,
    output logic              underrun
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [PTR_W-1:0]  wr_ptr;
    logic [CNT_W-1:0]  count_q;
    logic              do_push;
    logic              do_pop;
    logic              underrun_q;

    always_comb begin
        do_push = push && (count_q != FULL_CNT);
        do_pop  = pop && (count_q != '0);
        wr_ptr  = rd_ptr_q + count_q[PTR_W-1:0];
        unique case ({do_push, do_pop})
            2'b10:   count_nxt = count_q + CNT_W'(1);
            2'b01:   count_nxt = count_q - CNT_W'(1);
            default: count_nxt = count_q;
        endcase
    end

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_ptr_q   <= '0;
            count_q    <= '0;
            underrun_q <= 1'b0;
        end else begin
            count_q    <= count_nxt;
            underrun_q <= pop && (count_q == '0);
            if (do_pop) begin
                rd_ptr_q <= rd_ptr_q + PTR_W'(1);
            end
        end
    end

    assign rdata    = mem[rd_ptr_q];
    assign count    = count_q;
    assign underrun = underrun_q;

endmodule

// File: rtl/cfd_level_fsm.sv
// Picks the threshold in force and steers a crossing to a DMA request or a flag.
module cfd_level_fsm
    import cfd_pkg::*;
#(
    parameter int unsigned THR_W = 5,
    parameter int unsigned CNT_W = THR_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             xfer_active,
    input  logic             xfer_dir,
    input  logic [CNT_W-1:0] level_nxt,
    input  logic [CNT_W-1:0] level,
    input  logic             rx_dma_en,
    input  logic [THR_W-1:0] hi_lvl,
    input  logic             tx_dma_en,
    input  logic [THR_W-1:0] lo_lvl,
    output logic             rx_dma_req,
    output logic             rx_flag,
    output logic             tx_dma_req,
    output logic             tx_flag
);

    lvl_state_e state_q;
    lvl_state_e state_d;
    logic       above_hi;
    logic       below_lo;

    always_comb begin
        if (!xfer_active && (level_nxt == '0)) begin
            state_d = LV_QUIET;
        end else if (xfer_dir) begin
            state_d = LV_RECV;
        end else begin
            state_d = LV_SEND;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= LV_QUIET;
        end else begin
            state_q <= state_d;
        end
    end

    assign above_hi = level > CNT_W'(hi_lvl);
    assign below_lo = level < CNT_W'(lo_lvl);

    always_comb begin
        rx_dma_req = 1'b0;
        rx_flag    = 1'b0;
        tx_dma_req = 1'b0;
        tx_flag    = 1'b0;
        unique case (state_q)
            LV_QUIET: ;
            LV_RECV: begin
                rx_dma_req = above_hi && rx_dma_en;
                rx_flag    = above_hi && !rx_dma_en;
            end
            LV_SEND: begin
                tx_dma_req = below_lo && tx_dma_en;
                tx_flag    = below_lo && !tx_dma_en;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/card_fifo_dma.sv
module card_fifo_dma
    import cfd_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned DEPTH  = 32,
    localparam int unsigned PTR_W = $clog2(DEPTH),
    localparam int unsigned CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xfer_active,
    input  logic              xfer_dir,
    input  logic              cfg_we,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    input  logic              reg_push,
    input  logic              reg_pop,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              card_push,
    input  logic              card_pop,
    input  logic [DATA_W-1:0] card_wdata,
    output logic [DATA_W-1:0] fifo_rdata,
    output logic [CNT_W-1:0]  level,
    output logic              underrun,
    output logic              rx_dma_req,
    output logic              rx_flag,
    output logic              tx_dma_req,
    output logic              tx_flag
);

    logic              rx_en_q;
    logic              tx_en_q;
    logic [PTR_W-1:0]  hi_q;
    logic [PTR_W-1:0]  lo_q;
    logic              push_sel;
    logic              pop_sel;
    logic [DATA_W-1:0] wdata_sel;
    logic [CNT_W-1:0]  level_nxt;

    // Configuration register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_en_q <= 1'b0;
            tx_en_q <= 1'b0;
            hi_q    <= '1;
            lo_q    <= '0;
        end else if (cfg_we) begin
            rx_en_q <= cfg_wdata[CFG_RX_EN];
            tx_en_q <= cfg_wdata[CFG_TX_EN];
            hi_q    <= cfg_wdata[CFG_HI_LSB +: PTR_W];
            lo_q    <= cfg_wdata[CFG_LO_LSB +: PTR_W];
        end
    end

    always_comb begin
        cfg_rdata                        = '0;
        cfg_rdata[CFG_RX_EN]             = rx_en_q;
        cfg_rdata[CFG_TX_EN]             = tx_en_q;
        cfg_rdata[CFG_HI_LSB +: PTR_W]   = hi_q;
        cfg_rdata[CFG_LO_LSB +: PTR_W]   = lo_q;
    end

    // Direction routing: receive = card writes, registers read
    assign push_sel  = xfer_dir ? card_push  : reg_push;
    assign pop_sel   = xfer_dir ? reg_pop    : card_pop;
    assign wdata_sel = xfer_dir ? card_wdata : reg_wdata;

    cfd_store #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push_sel),
        .wdata     (wdata_sel),
        .pop       (pop_sel),
        .rdata     (fifo_rdata),
        .count     (level),
        .count_nxt (level_nxt),
        .underrun  (underrun)
    );

    cfd_level_fsm #(
        .THR_W (PTR_W),
        .CNT_W (CNT_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .xfer_active (xfer_active),
        .xfer_dir    (xfer_dir),
        .level_nxt   (level_nxt),
        .level       (level),
        .rx_dma_en   (rx_en_q),
        .hi_lvl      (hi_q),
        .tx_dma_en   (tx_en_q),
        .lo_lvl      (lo_q),
        .rx_dma_req  (rx_dma_req),
        .rx_flag     (rx_flag),
        .tx_dma_req  (tx_dma_req),
        .tx_flag     (tx_flag)
    );

endmodule

module card_fifo_dma_chk #(
    parameter int unsigned DEPTH = 32,
    parameter int unsigned CNT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             xfer_active,
    input logic             xfer_dir,
    input logic             reg_push,
    input logic             reg_pop,
    input logic             card_push,
    input logic             card_pop,
    input logic [15:0]      cfg_rdata,
    input logic [CNT_W-1:0] level,
    input logic             underrun,
    input logic             rx_dma_req,
    input logic             rx_flag,
    input logic             tx_dma_req,
    input logic             tx_flag
);

    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic wr_side;
    logic rd_side;
    assign wr_side = xfer_dir ? card_push : reg_push;
    assign rd_side = xfer_dir ? reg_pop : card_pop;

    // R1
    level_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        level <= FULL_CNT);

    // R3
    full_push_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == FULL_CNT && wr_side && !rd_side) |=> level == FULL_CNT);

    // R4
    empty_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (level == '0 && rd_side && !wr_side) |=> (underrun && level == '0));

    // R4
    underrun_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        underrun |-> $past(level) == '0);

    // R5
    rx_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dma_req |-> (cfg_rdata[15] && !rx_flag)) and (rx_flag |-> !cfg_rdata[15]));

    // R6
    tx_steer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_dma_req |-> (cfg_rdata[7] && !tx_flag)) and (tx_flag |-> !cfg_rdata[7]));

    // R6
    side_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_dma_req || rx_flag) |-> !(tx_dma_req || tx_flag));

    // R7
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(xfer_active) && level == '0) |->
            !(rx_dma_req || rx_flag || tx_dma_req || tx_flag));

endmodule

bind card_fifo_dma card_fifo_dma_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/card_fifo_dma_test.sv
module card_fifo_dma_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 8;

    // {card_push, reg_pop, card_wdata, exp_level, exp_rx_flag, exp_head}
    localparam logic [40:0] VEC [NVEC] = '{
        {1'b1, 1'b0, 16'hA001, 6'd1, 1'b0, 16'hA001},
        {1'b1, 1'b0, 16'hA002, 6'd2, 1'b0, 16'hA001},
        {1'b1, 1'b0, 16'hA003, 6'd3, 1'b1, 16'hA001},
        {1'b1, 1'b1, 16'hA004, 6'd3, 1'b1, 16'hA002},
        {1'b0, 1'b1, 16'h0000, 6'd2, 1'b0, 16'hA003},
        {1'b1, 1'b0, 16'hA006, 6'd3, 1'b1, 16'hA003},
        {1'b0, 1'b1, 16'h0000, 6'd2, 1'b0, 16'hA004},
        {1'b0, 1'b1, 16'h0000, 6'd1, 1'b0, 16'hA006}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        xfer_active = 1'b0;
    logic        xfer_dir = 1'b0;
    logic        cfg_we = 1'b0;
    logic [15:0] cfg_wdata = '0;
    logic [15:0] cfg_rdata;
    logic        reg_push = 1'b0;
    logic        reg_pop = 1'b0;
    logic [15:0] reg_wdata = '0;
    logic        card_push = 1'b0;
    logic        card_pop = 1'b0;
    logic [15:0] card_wdata = '0;
    logic [15:0] fifo_rdata;
    logic [5:0]  level;
    logic        underrun;
    logic        rx_dma_req;
    logic        rx_flag;
    logic        tx_dma_req;
    logic        tx_flag;

    int n_chk = 0;
    int n_bad = 0;
    logic [15:0] held;

    always #(CLK_PERIOD/2) clk = ~clk;

    card_fifo_dma uut (
        .clk(clk), .rst_n(rst_n), .xfer_active(xfer_active), .xfer_dir(xfer_dir),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .reg_push(reg_push), .reg_pop(reg_pop), .reg_wdata(reg_wdata),
        .card_push(card_push), .card_pop(card_pop), .card_wdata(card_wdata),
        .fifo_rdata(fifo_rdata), .level(level), .underrun(underrun),
        .rx_dma_req(rx_dma_req), .rx_flag(rx_flag),
        .tx_dma_req(tx_dma_req), .tx_flag(tx_flag)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FIFO check FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Advance one clock; returns at the falling edge
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_cfg(input logic [15:0] w);
        cfg_we = 1'b1; cfg_wdata = w;
        cyc();
        cfg_we = 1'b0;
    endtask

    task automatic outs(input string req, input logic [3:0] exp);
        chk(req, "rxreq,rxflag,txreq,txflag",
            {28'd0, rx_dma_req, rx_flag, tx_dma_req, tx_flag}, {28'd0, exp});
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FIFO check FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk + 1 - n_bad, n_chk + 1);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R8 reset state
        chk("R8", "cfg reset", cfg_rdata, 16'h1F00);
        chk("R1", "level reset", level, 0);
        outs("R7", 4'b0000);
        chk("R4", "underrun reset", underrun, 0);

        // Table walk: receive direction, upper level 2, DMA off (R1 R5)
        xfer_active = 1'b1; xfer_dir = 1'b1;
        set_cfg(16'h0200);
        chk("R8", "cfg readback", cfg_rdata, 16'h0200);
        for (int i = 0; i < NVEC; i++) begin
            card_push = VEC[i][40]; reg_pop = VEC[i][39]; card_wdata = VEC[i][38:23];
            cyc();
            card_push = 1'b0; reg_pop = 1'b0;
            chk("R1", "table level", level, VEC[i][22:17]);
            chk("R5", "table rx_flag", rx_flag, VEC[i][16]);
            chk("R1", "table head", fifo_rdata, VEC[i][15:0]);
            chk("R5", "table rx_req", rx_dma_req, 0);
        end

        // R5 level 1 > upper 0, DMA off -> flag; then R9 enable DMA
        set_cfg(16'h0000);
        outs("R5", 4'b0100);
        set_cfg(16'h8000);
        outs("R9", 4'b1000);

        // R2 wrong-side strobes ignored in receive
        reg_push = 1'b1; reg_wdata = 16'hDEAD; card_pop = 1'b1;
        cyc();
        reg_push = 1'b0; card_pop = 1'b0;
        chk("R2", "rx ignore level", level, 1);
        chk("R2", "rx ignore head", fifo_rdata, 16'hA006);

        reg_pop = 1'b1; cyc(); reg_pop = 1'b0;
        chk("R1", "drained", level, 0);
        outs("R5", 4'b0000);

        // R4 pop at empty
        held = fifo_rdata;
        reg_pop = 1'b1; cyc(); reg_pop = 1'b0;
        chk("R4", "underrun pulse", underrun, 1);
        chk("R4", "level after underrun", level, 0);
        chk("R4", "head after underrun", fifo_rdata, held);
        cyc();
        chk("R4", "underrun one cycle", underrun, 0);

        // R7 quiet with lower level armed
        xfer_active = 1'b0; xfer_dir = 1'b0;
        set_cfg(16'h0083);
        outs("R7", 4'b0000);
        xfer_active = 1'b1;
        cyc();
        outs("R6", 4'b0010);
        set_cfg(16'h0003);
        outs("R6", 4'b0001);

        // R6 transmit fill via registers
        for (int i = 1; i <= 3; i++) begin
            reg_push = 1'b1; reg_wdata = 16'hB000 + 16'(i);
            cyc();
            reg_push = 1'b0;
            chk("R6", "tx fill level", level, 6'(i));
            chk("R6", "tx flag", tx_flag, (i < 3) ? 1 : 0);
        end
        chk("R2", "tx head", fifo_rdata, 16'hB001);
        card_pop = 1'b1; cyc(); card_pop = 1'b0;
        chk("R2", "card pop level", level, 2);
        chk("R6", "tx flag below", tx_flag, 1);
        chk("R1", "tx head next", fifo_rdata, 16'hB002);
        card_push = 1'b1; card_wdata = 16'hBEEF; cyc(); card_push = 1'b0;
        chk("R2", "tx card push ignored", level, 2);

        // R7 inactive but nonempty keeps direction
        xfer_active = 1'b0;
        cyc();
        outs("R7", 4'b0001);
        card_pop = 1'b1; cyc(); cyc(); card_pop = 1'b0;
        chk("R1", "tx drained", level, 0);
        outs("R7", 4'b0000);

        // R3 / R5 boundary at full with upper level 31
        xfer_active = 1'b1; xfer_dir = 1'b1;
        set_cfg(16'h1F00);
        for (int i = 0; i < 31; i++) begin
            card_push = 1'b1; card_wdata = 16'hC000 + 16'(i);
            cyc();
        end
        card_push = 1'b0;
        chk("R1", "31 words", level, 31);
        chk("R5", "no flag at 31", rx_flag, 0);
        card_push = 1'b1; card_wdata = 16'hC01F; cyc();
        chk("R5", "flag at 32", rx_flag, 1);
        chk("R1", "full", level, 32);
        card_wdata = 16'hFFFF; cyc(); card_push = 1'b0;
        chk("R3", "push at full", level, 32);
        card_push = 1'b1; reg_pop = 1'b1; card_wdata = 16'hEEEE; cyc();
        card_push = 1'b0; reg_pop = 1'b0;
        chk("R3", "push+pop at full", level, 31);
        for (int i = 1; i < 32; i++) begin
            chk("R3", "drain order", fifo_rdata, 16'hC000 + 16'(i));
            reg_pop = 1'b1; cyc(); reg_pop = 1'b0;
        end
        chk("R3", "drain end", level, 0);
        chk("R4", "no underrun on drain", underrun, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule